// File: doc/BRIEF.md
# Halfword Zero-Extending Load Unit

This block runs one halfword load for a 64-bit big-endian RISC core. It is started with a 32-bit instruction word and accepts four load forms. Two forms add a sign-extended 16-bit displacement to a base register. Two forms add the full contents of an index register. One form of each pair also writes the address back to the base register. The unit reads the base and index registers through two combinational read ports of a 32-entry register file.

It fetches the two bytes through a byte-wide read port, one byte per handshake. The high-order byte comes first. Because of this, odd addresses and addresses that cross the 32-bit wrap need no special path. It writes the zero-extended halfword to the destination register through a single write port. For the update forms it then writes the address to the base register in the next cycle.

A one-cycle done strobe ends every operation. On a word the unit does not accept, the done strobe comes with an illegal flag, and no memory read or register write takes place.

Top module: `hload_unit`

## Requirements
- R1: Instruction bits use big-endian numbering (bit 0 is the MSB, which is `instr[31]`). The primary opcode is `instr[31:26]`, the destination is `instr[25:21]`, base A is `instr[20:16]`, index B is `instr[15:11]`, the displacement is `instr[15:0]` and the extended opcode is `instr[10:1]`. Opcode 40 selects the displacement load and opcode 41 the displacement load with update. Opcode 31 with extended opcode 279 selects the indexed load, and opcode 31 with extended opcode 311 the indexed load with update.
- R2: The displacement forms compute the address as the base plus the sign-extended displacement. The sum is a 64-bit wrapping add, and its low 32 bits are the address.
- R3: The indexed forms compute the address as the base plus all 64 bits of register B, truncated to 32 bits.
- R4: In the two forms without update, a base field of 0 supplies the value zero, and the contents of register 0 are not used.
- R5: The unit issues exactly two byte reads, first at the address and then at the address plus one (modulo 2^32). The destination receives {48 zero bits, first byte, second byte}.
- R6: Any alignment, odd addresses included, completes normally with no illegal flag.
- R7: The update forms write the destination in one cycle and {32 zero bits, address} to the base register in the following cycle. When base equals destination, that register ends up holding the address.
- R8: The unit flags as illegal any other opcode, opcode 31 with any other extended opcode, and an update form whose base field is 0. An illegal word asserts illegal together with done and makes no memory read and no register write.
- R9: Done is high for exactly one cycle. For a legal load it rises in the cycle after the final register write.
- R10: While an operation is in progress (busy high), start is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation with `instr` (accepted when idle) |
| instr | input | 32 | Instruction word |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion strobe |
| illegal | output | 1 | Valid with done: word not accepted |
| rf_ra_idx | output | 5 | Register file read index for base A |
| rf_ra_data | input | 64 | Contents of register `rf_ra_idx` |
| rf_rb_idx | output | 5 | Register file read index for index B |
| rf_rb_data | input | 64 | Contents of register `rf_rb_idx` |
| mem_req | output | 1 | Byte read request, held until `mem_rvalid` |
| mem_addr | output | 32 | Byte address of the request |
| mem_rdata | input | 8 | Returned byte |
| mem_rvalid | input | 1 | Returned byte is valid |
| rf_we | output | 1 | Register write enable |
| rf_widx | output | 5 | Register write index |
| rf_wdata | output | 64 | Register write data |

## Verification
Some properties are checked on every cycle. The second byte address follows the first by one, and a base write-back always follows a destination write. A rejected word produces neither a memory read nor a register write. Done is a single-cycle pulse that follows the last write. Other behaviour shows only in the bench's scenarios, which compare every read address and written value with an independent model:
- the opcode and extended-opcode decode,
- sign extension of negative displacements,
- truncation of 64-bit sums,
- the register-zero rule,
- the wrap from the top of the address space,
- the final contents of a register used as both base and destination,
- a start pulse ignored in mid-operation.

// File: rtl/hload_pkg.sv
package hload_pkg;
  localparam int XLEN = 64;
  localparam int AW   = 32;
  localparam int NREG = 32;
  localparam int RIDX = $clog2(NREG);
  localparam int IW   = 32;
  localparam int DW   = 16;
  localparam int BW   = 8;

  localparam logic [5:0] PO_DISP     = 6'd40;
  localparam logic [5:0] PO_DISP_UPD = 6'd41;
  localparam logic [5:0] PO_EXT      = 6'd31;
  localparam logic [9:0] XO_IDX      = 10'd279;
  localparam logic [9:0] XO_IDX_UPD  = 10'd311;

  typedef enum logic [2:0] {K_DISP, K_DISP_UPD, K_IDX, K_IDX_UPD, K_BAD} kind_e;

  typedef enum logic [2:0] {
    S_IDLE, S_DEC, S_RHI, S_RLO, S_WDST, S_WBASE, S_FIN
  } state_e;

  function automatic logic kind_updates(kind_e k);
    return (k == K_DISP_UPD) || (k == K_IDX_UPD);
  endfunction

  function automatic logic kind_indexed(kind_e k);
    return (k == K_IDX) || (k == K_IDX_UPD);
  endfunction

  function automatic logic [XLEN-1:0] sext_disp(logic [DW-1:0] d);
    return {{(XLEN-DW){d[DW-1]}}, d};
  endfunction

  function automatic logic [XLEN-1:0] wrap_sum(logic [XLEN-1:0] a, logic [XLEN-1:0] b);
    return a + b;
  endfunction

  function automatic logic [XLEN-1:0] zext_half(logic [BW-1:0] hi, logic [BW-1:0] lo);
    return {{(XLEN-2*BW){1'b0}}, hi, lo};
  endfunction
endpackage

// File: rtl/hload_decode.sv
module hload_decode
  import hload_pkg::*;
(
  input  logic [IW-1:0]   instr,
  output kind_e           kind,
  output logic            legal,
  output logic [RIDX-1:0] rt,
  output logic [RIDX-1:0] ra,
  output logic [RIDX-1:0] rb,
  output logic [DW-1:0]   disp
);
  logic [5:0] opcd;
  logic [9:0] xo;
  logic       rc_unused;

  assign opcd      = instr[31:26];
  assign rt        = instr[25:21];
  assign ra        = instr[20:16];
  assign rb        = instr[15:11];
  assign disp      = instr[DW-1:0];
  assign xo        = instr[10:1];
  assign rc_unused = instr[0];

  always_comb begin
    kind = K_BAD;
    unique case (opcd)
      PO_DISP:     kind = K_DISP;
      PO_DISP_UPD: kind = K_DISP_UPD;
      PO_EXT: begin
        if (xo == XO_IDX)          kind = K_IDX;
        else if (xo == XO_IDX_UPD) kind = K_IDX_UPD;
      end
      default:     kind = K_BAD;
    endcase
  end

  // update forms with base field 0 are rejected
  assign legal = (kind != K_BAD) && !(kind_updates(kind) && (ra == '0));
endmodule

// File: rtl/hload_agen.sv
module hload_agen
  import hload_pkg::*;
(
  input  kind_e           kind,
  input  logic [RIDX-1:0] ra,
  input  logic [DW-1:0]   disp,
  input  logic [XLEN-1:0] ra_data,
  input  logic [XLEN-1:0] rb_data,
  output logic [AW-1:0]   ea
);
  logic [XLEN-1:0]    base;
  logic [XLEN-1:0]    offset;
  logic [XLEN-1:0]    sum;
  logic [XLEN-AW-1:0] sum_unused_hi;

  // register zero reads as literal zero only when no update is done
  assign base   = ((ra == '0) && !kind_updates(kind)) ? '0 : ra_data;
  assign offset = kind_indexed(kind) ? rb_data : sext_disp(disp);
  assign sum    = wrap_sum(base, offset);
  assign {sum_unused_hi, ea} = sum;
endmodule

// File: rtl/hload_unit.sv
module hload_unit
  import hload_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [IW-1:0]   instr,
  output logic            busy,
  output logic            done,
  output logic            illegal,
  output logic [RIDX-1:0] rf_ra_idx,
  input  logic [XLEN-1:0] rf_ra_data,
  output logic [RIDX-1:0] rf_rb_idx,
  input  logic [XLEN-1:0] rf_rb_data,
  output logic            mem_req,
  output logic [AW-1:0]   mem_addr,
  input  logic [BW-1:0]   mem_rdata,
  input  logic            mem_rvalid,
  output logic            rf_we,
  output logic [RIDX-1:0] rf_widx,
  output logic [XLEN-1:0] rf_wdata
);
  state_e          st;
  logic [IW-1:0]   instr_q;
  logic [RIDX-1:0] rt_q, ra_q;
  logic            upd_q, ill_q;
  logic [AW-1:0]   ea_q;
  logic [BW-1:0]   hi_q, lo_q;

  kind_e           dec_kind;
  logic            dec_legal;
  logic [RIDX-1:0] dec_rt, dec_ra, dec_rb;
  logic [DW-1:0]   dec_disp;
  logic [AW-1:0]   agen_ea;

  hload_decode u_dec (
    .instr (instr_q),
    .kind  (dec_kind),
    .legal (dec_legal),
    .rt    (dec_rt),
    .ra    (dec_ra),
    .rb    (dec_rb),
    .disp  (dec_disp)
  );

  hload_agen u_agen (
    .kind    (dec_kind),
    .ra      (dec_ra),
    .disp    (dec_disp),
    .ra_data (rf_ra_data),
    .rb_data (rf_rb_data),
    .ea      (agen_ea)
  );

  assign rf_ra_idx = dec_ra;
  assign rf_rb_idx = dec_rb;

  // named events for the checks below
  logic ev_wr_dst, ev_wr_base, ev_dec_bad;
  assign ev_wr_dst  = (st == S_WDST);
  assign ev_wr_base = (st == S_WBASE);
  assign ev_dec_bad = (st == S_DEC) && !dec_legal;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      instr_q <= '0;
      rt_q    <= '0;
      ra_q    <= '0;
      upd_q   <= 1'b0;
      ill_q   <= 1'b0;
      ea_q    <= '0;
      hi_q    <= '0;
      lo_q    <= '0;
    end else begin
      unique case (st)
        S_IDLE: if (start) begin
          instr_q <= instr;
          st      <= S_DEC;
        end
        S_DEC: begin
          rt_q  <= dec_rt;
          ra_q  <= dec_ra;
          upd_q <= kind_updates(dec_kind);
          ea_q  <= agen_ea;
          ill_q <= !dec_legal;
          st    <= dec_legal ? S_RHI : S_FIN;
        end
        S_RHI: if (mem_rvalid) begin
          hi_q <= mem_rdata;
          st   <= S_RLO;
        end
        S_RLO: if (mem_rvalid) begin
          lo_q <= mem_rdata;
          st   <= S_WDST;
        end
        S_WDST:  st <= upd_q ? S_WBASE : S_FIN;
        S_WBASE: st <= S_FIN;
        S_FIN:   st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy     = (st != S_IDLE);
  assign mem_req  = (st == S_RHI) || (st == S_RLO);
  assign mem_addr = (st == S_RLO) ? (ea_q + AW'(1)) : ea_q;
  assign rf_we    = ev_wr_dst || ev_wr_base;
  assign rf_widx  = ev_wr_base ? ra_q : rt_q;
  assign rf_wdata = ev_wr_base ? {{(XLEN-AW){1'b0}}, ea_q} : zext_half(hi_q, lo_q);
  assign done     = (st == S_FIN);
  assign illegal  = (st == S_FIN) && ill_q;

  AST_LO_FOLLOWS_HI: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && $past(mem_req) && $past(mem_rvalid)) |-> (mem_addr == $past(mem_addr) + AW'(1))); // R5
  AST_BASE_AFTER_DEST: assert property (@(posedge clk) disable iff (!rst_n)
    ev_wr_base |-> $past(ev_wr_dst)); // R7
  AST_BAD_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    ev_dec_bad |=> (!mem_req && !rf_we && illegal)); // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9
  AST_DONE_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !illegal) |-> $past(rf_we)); // R9
endmodule

// File: tb/hload_unit_tb.sv
`timescale 1ns/1ps
module hload_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] instr = '0;
  logic        busy, done, illegal;
  logic [4:0]  rf_ra_idx, rf_rb_idx, rf_widx;
  logic [63:0] rf_ra_data, rf_rb_data, rf_wdata;
  logic        mem_req, mem_rvalid, rf_we;
  logic [31:0] mem_addr;
  logic [7:0]  mem_rdata;

  int total = 0;
  int bad = 0;
  string cur_tag = "R1";

  always #10 clk = ~clk;

  hload_unit u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .instr(instr),
    .busy(busy), .done(done), .illegal(illegal),
    .rf_ra_idx(rf_ra_idx), .rf_ra_data(rf_ra_data),
    .rf_rb_idx(rf_rb_idx), .rf_rb_data(rf_rb_data),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_rdata(mem_rdata), .mem_rvalid(mem_rvalid),
    .rf_we(rf_we), .rf_widx(rf_widx), .rf_wdata(rf_wdata)
  );

  function automatic logic [63:0] init_val(int i);
    case (i)
      0:  return 64'h0000_0000_0000_4444;
      1:  return 64'h0000_0000_0000_1000;
      2:  return 64'hFFFF_FFFF_FFFF_FFFF;
      3:  return 64'h1234_5678_FFFF_FFF0;
      4:  return 64'h0000_0000_0000_0203;
      5:  return 64'h0000_0000_FFFF_FFFF;
      default: return 64'h0000_0000_2000_0000 + 64'(i) * 64'h111;
    endcase
  endfunction

  function automatic logic [7:0] mb(logic [31:0] a);
    return a[7:0] ^ a[15:8] ^ a[23:16] ^ a[31:24] ^ 8'hA5 ^ {a[3:0], 4'h0};
  endfunction

  // environment: register file and byte memory
  logic [63:0] rfm [32];
  assign rf_ra_data = rfm[rf_ra_idx];
  assign rf_rb_data = rfm[rf_rb_idx];
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 32; i++) rfm[i] <= init_val(i);
    end else if (rf_we) begin
      rfm[rf_widx] <= rf_wdata;
    end
  end

  logic rv_r = 1'b0;
  logic [7:0] rd_r = '0;
  assign mem_rvalid = rv_r;
  assign mem_rdata  = rd_r;
  always @(posedge clk) begin
    if (!rst_n) rv_r <= 1'b0;
    else if (mem_req && !rv_r) begin rv_r <= 1'b1; rd_r <= mb(mem_addr); end
    else rv_r <= 1'b0;
  end

  // scoreboard queues
  logic [4:0]  q_widx [$];
  logic [63:0] q_wdat [$];
  string       q_wtag [$];
  logic [31:0] q_addr [$];
  string       q_atag [$];
  logic        q_ill  [$];

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // monitor
  logic prev_we = 1'b0;
  logic prev_done = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (rf_we) begin
        if (q_widx.size() == 0) chk(0, cur_tag, "unexpected register write", {59'd0, rf_widx}, 64'd0);
        else begin
          logic [4:0] ei; logic [63:0] ed; string et;
          ei = q_widx.pop_front(); ed = q_wdat.pop_front(); et = q_wtag.pop_front();
          chk(rf_widx == ei, et, "write index", {59'd0, rf_widx}, {59'd0, ei});
          chk(rf_wdata == ed, et, "write data", rf_wdata, ed);
        end
      end
      if (mem_req && mem_rvalid) begin
        if (q_addr.size() == 0) chk(0, cur_tag, "unexpected memory read", {32'd0, mem_addr}, 64'd0);
        else begin
          logic [31:0] ea; string at;
          ea = q_addr.pop_front(); at = q_atag.pop_front();
          chk(mem_addr == ea, at, "read address", {32'd0, mem_addr}, {32'd0, ea});
        end
      end
      if (done) begin
        if (q_ill.size() == 0) chk(0, cur_tag, "unexpected done", 64'd1, 64'd0);
        else begin
          logic ei;
          ei = q_ill.pop_front();
          chk(illegal == ei, ei ? "R8" : "R6", "illegal flag", {63'd0, illegal}, {63'd0, ei});
          // R9: done follows the final write
          if (!ei) chk(prev_we, "R9", "done after write", {63'd0, prev_we}, 64'd1);
        end
        chk(!prev_done, "R9", "done single cycle", {63'd0, prev_done}, 64'd0);
      end
      prev_we = rf_we;
      prev_done = done;
    end
  end

  function automatic logic [31:0] dform(logic [5:0] op, logic [4:0] rt, logic [4:0] ra, logic [15:0] d);
    return {op, rt, ra, d};
  endfunction
  function automatic logic [31:0] xform(logic [4:0] rt, logic [4:0] ra, logic [4:0] rb, logic [9:0] xo);
    return {6'd31, rt, ra, rb, xo, 1'b0};
  endfunction

  // driver: computes expectations, then issues the word
  task automatic run_op(input logic [31:0] w, input string tag, input bit poke_busy);
    logic [5:0] op; logic [4:0] rt, ra, rb; logic [9:0] xo; logic [15:0] d;
    bit idx, upd, legal; logic [63:0] base, off, sum, res; logic [31:0] ea;
    int n;
    op = w[31:26]; rt = w[25:21]; ra = w[20:16]; rb = w[15:11]; xo = w[10:1]; d = w[15:0];
    idx = (op == 6'd31) && (xo == 10'd279 || xo == 10'd311);
    upd = (op == 6'd41) || (op == 6'd31 && xo == 10'd311);
    legal = (op == 6'd40 || op == 6'd41 || idx) && !(upd && ra == 0);
    cur_tag = tag;
    ea = '0; res = '0;
    if (legal) begin
      base = (ra == 0 && !upd) ? 64'd0 : rfm[ra];
      off  = idx ? rfm[rb] : {{48{d[15]}}, d};
      sum  = base + off;
      ea   = sum[31:0];
      res  = {48'd0, mb(ea), mb(ea + 32'd1)};
      q_addr.push_back(ea); q_atag.push_back(tag);
      q_addr.push_back(ea + 32'd1); q_atag.push_back(tag);
      q_widx.push_back(rt); q_wdat.push_back(res); q_wtag.push_back(tag);
      if (upd) begin
        q_widx.push_back(ra); q_wdat.push_back({32'd0, ea}); q_wtag.push_back(tag);
      end
    end
    q_ill.push_back(!legal);
    @(negedge clk);
    instr = w; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke_busy) begin
      // R10: a second word offered mid-operation must have no effect
      @(negedge clk);
      instr = dform(6'd40, 5'd20, 5'd1, 16'h0100); start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    n = 0;
    while (!done && n < 100) begin @(negedge clk); n++; end
    chk(done, tag, "completion", {63'd0, done}, 64'd1);
    @(negedge clk);
    if (legal) begin
      if (upd) chk(rfm[ra] == {32'd0, ea}, tag, "final base register", rfm[ra], {32'd0, ea});
      else     chk(rfm[rt] == res, tag, "final destination", rfm[rt], res);
    end
    repeat (3) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired: actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !done && !mem_req && !rf_we, "R9", "reset state",
        {60'd0, busy, done, mem_req, rf_we}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    run_op(dform(6'd40, 5'd6, 5'd1, 16'h0010), "R1", 0);   // R1 R2 displacement form
    run_op(dform(6'd40, 5'd7, 5'd1, 16'hFFFE), "R2", 0);   // R2 negative displacement
    run_op(dform(6'd40, 5'd8, 5'd0, 16'h0005), "R4", 0);   // R4 base zero, R6 odd address
    run_op(xform(5'd9, 5'd0, 5'd4, 10'd279), "R4", 0);     // R4 R3 indexed with zero base
    run_op(xform(5'd10, 5'd1, 5'd2, 10'd279), "R3", 0);    // R3 full 64-bit index
    run_op(dform(6'd40, 5'd11, 5'd3, 16'h7FFF), "R2", 0);  // R2 64-bit sum truncated
    run_op(dform(6'd40, 5'd12, 5'd5, 16'h0000), "R5", 0);  // R5 second byte wraps to 0
    run_op(dform(6'd40, 5'd19, 5'd1, 16'h0333), "R6", 0);  // R6 odd address
    run_op(dform(6'd41, 5'd13, 5'd14, 16'h0008), "R7", 0); // R7 update form
    run_op(dform(6'd41, 5'd13, 5'd14, 16'h0008), "R7", 0); // R7 base stepped again
    run_op(xform(5'd15, 5'd16, 5'd4, 10'd311), "R7", 0);   // R7 indexed update
    run_op(dform(6'd41, 5'd17, 5'd17, 16'h0003), "R7", 0); // R7 base equals destination
    run_op(xform(5'd18, 5'd18, 5'd1, 10'd311), "R7", 0);   // R7 collision, indexed
    run_op(dform(6'd32, 5'd6, 5'd1, 16'h0010), "R8", 0);   // R8 foreign opcode
    run_op(xform(5'd6, 5'd1, 5'd2, 10'd280), "R8", 0);     // R8 foreign extended opcode
    run_op(dform(6'd41, 5'd6, 5'd0, 16'h0010), "R8", 0);   // R8 update with base 0
    run_op(xform(5'd6, 5'd0, 5'd2, 10'd311), "R8", 0);     // R8 indexed update with base 0
    run_op(dform(6'd40, 5'd21, 5'd1, 16'h0042), "R10", 1); // R10 start while busy
    chk(q_widx.size() == 0 && q_addr.size() == 0 && q_ill.size() == 0 && !busy, "R10",
        "scoreboard drained", {32'(q_widx.size()), 31'd0, busy}, 64'd0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule